// File: doc/BRIEF.md
# Dual-Edge Set/Clear Level Detector

This block turns two independent edge streams into one output level per lane. A rising edge on the set input drives the lane output high, and a rising edge on the clear input drives it low. There is no shared clock. Each lane uses two D flops. One flop is clocked only by the set input and the other only by the clear input. The lane output is the XOR of the two stored bits. This avoids building pulse generators in front of a set/reset latch.

A typical use is as the phase comparator of a clock-recovery or synthesis loop. The fraction of time the output is high then follows the delay from a set edge to the following clear edge. The edges on the two inputs of a lane must be spaced further apart than the flop clock-to-output delay. Edges closer than that are a usage error. The output for such edges is not defined.

Top module: `edge_pd_bank`

## Requirements
- R1: A rising edge on `set_edge[i]` makes `level_o[i]` equal 1, whatever its previous value.
- R2: A rising edge on `clr_edge[i]` makes `level_o[i]` equal 0, whatever its previous value.
- R3: Further set edges with no clear edge between them leave `level_o[i]` at 1.
- R4: Further clear edges with no set edge between them leave `level_o[i]` at 0.
- R5: After a set edge, the two stored bits of a lane differ. After a clear edge, they are equal. The output is their XOR.
- R6: While `rst` (active high, asynchronous) is 1, both stored bits of every lane are 0 and `level_o` is all zeros. Edges that arrive during reset have no effect.
- R7: Falling edges on either input never change `level_o`.
- R8: The lanes are independent. Edges on lane i change only `level_o[i]`.
- R9: The inputs are two equal-frequency trains. The clear train lags the set train by D in each period. In that case `level_o[i]` is high for exactly D of each period.
- R10: When a set edge and a clear edge both arrive in a short window, the output follows whichever came later, provided the two edges are spaced further apart than the flop delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Asynchronous active-high reset of all lanes |
| set_edge | input | LANES | Per-lane set input; its rising edge drives the lane output high |
| clr_edge | input | LANES | Per-lane clear input; its rising edge drives the lane output low |
| level_o | output | LANES | Per-lane output level |

## Verification
Two functions can land in the same cycle of the bench clock. The first case is a set edge and a clear edge of one lane inside a single 10 ns period. The second is an edge that arrives while reset is held. The bench places a set pulse and then a clear pulse only a few nanoseconds apart. It also places the reverse order. In both cases it expects the later edge to win. It also pulses set while reset is high and expects the output to stay low after release. In addition, random edges are spread across lanes and compared against a model of the most recent edge per lane. A fixed-offset run then measures the high time of the output against the set-to-clear delay.

// File: rtl/edge_pd_pkg.sv
package edge_pd_pkg;
  // Polarity of the cross-fed input of a capture flop
  typedef enum logic {
    FEED_DIRECT = 1'b0,
    FEED_INVERT = 1'b1
  } feed_pol_e;

  // Output level from the two stored bits
  function automatic logic pd_combine(input logic set_bit, input logic clr_bit);
    return set_bit ^ clr_bit;
  endfunction
endpackage

// File: rtl/edge_pd_capture.sv
module edge_pd_capture #(
  parameter edge_pd_pkg::feed_pol_e POL = edge_pd_pkg::FEED_DIRECT
) (
  input  logic rst,
  input  logic edge_i,
  input  logic feed_i,
  output logic bit_o
);
  logic d_next;

  generate
    if (POL == edge_pd_pkg::FEED_INVERT) begin : g_inv
      assign d_next = ~feed_i;
    end else begin : g_dir
      assign d_next = feed_i;
    end
  endgenerate

  always_ff @(posedge edge_i or posedge rst) begin
    if (rst) bit_o <= 1'b0;
    else     bit_o <= d_next;
  end
endmodule

// File: rtl/edge_pd_lane.sv
module edge_pd_lane (
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic level_o
);
  import edge_pd_pkg::*;

  logic set_bit;
  logic clr_bit;

  // Set side loads the inverse of the clear-side bit: bits end up different
  edge_pd_capture #(.POL(FEED_INVERT)) u_set (
    .rst   (rst),
    .edge_i(set_i),
    .feed_i(clr_bit),
    .bit_o (set_bit)
  );

  // Clear side copies the set-side bit: bits end up equal
  edge_pd_capture #(.POL(FEED_DIRECT)) u_clr (
    .rst   (rst),
    .edge_i(clr_i),
    .feed_i(set_bit),
    .bit_o (clr_bit)
  );

  assign level_o = pd_combine(set_bit, clr_bit);

  // R1
  set_drives_high_chk: assert property (@(negedge set_i) disable iff (rst) level_o == 1'b1);
  // R2
  clr_drives_low_chk: assert property (@(negedge clr_i) disable iff (rst) level_o == 1'b0);
  // R5
  set_bits_differ_chk: assert property (@(negedge set_i) disable iff (rst) set_bit != clr_bit);
  // R5
  clr_bits_equal_chk: assert property (@(negedge clr_i) disable iff (rst) set_bit == clr_bit);
  // R6
  reset_clears_chk: assert property (@(negedge rst) (set_bit == 1'b0) && (clr_bit == 1'b0));
endmodule

// File: rtl/edge_pd_bank.sv
module edge_pd_bank #(
  parameter int LANES = 2
) (
  input  logic             rst,
  input  logic [LANES-1:0] set_edge,
  input  logic [LANES-1:0] clr_edge,
  output logic [LANES-1:0] level_o
);
  localparam int LAST_LANE = LANES - 1;

  generate
    for (genvar g = 0; g <= LAST_LANE; g++) begin : g_lane
      edge_pd_lane u_lane (
        .rst    (rst),
        .set_i  (set_edge[g]),
        .clr_i  (clr_edge[g]),
        .level_o(level_o[g])
      );
    end
  endgenerate
endmodule

// File: tb/edge_pd_bank_test.sv
module edge_pd_bank_test;
  localparam int LANES = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LANES-1:0] set_edge = '0;
  logic [LANES-1:0] clr_edge = '0;
  logic [LANES-1:0] level_o;

  logic [LANES-1:0] model = '0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  edge_pd_bank #(.LANES(LANES)) uut (
    .rst     (rst),
    .set_edge(set_edge),
    .clr_edge(clr_edge),
    .level_o (level_o)
  );

  always #5 clk = ~clk;

  function automatic logic [LANES-1:0] apply_edge(input logic [LANES-1:0] cur,
                                                  input int lane, input bit is_set);
    logic [LANES-1:0] r = cur;
    r[lane] = is_set;
    return r;
  endfunction

  task automatic check(input string req, input logic [LANES-1:0] act,
                       input logic [LANES-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: level_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // One rising edge on one lane, then its falling edge, checking both
  task automatic do_edge(input int lane, input bit is_set, input string req);
    @(posedge clk);
    #1;
    if (is_set) set_edge[lane] = 1'b1; else clr_edge[lane] = 1'b1;
    model = apply_edge(model, lane, is_set);
    #2 check(req, level_o, model);
    #1;
    set_edge[lane] = 1'b0;
    clr_edge[lane] = 1'b0;
    #2 check("R7", level_o, model);
  endtask

  // Two edges of one lane inside one clock period; the later must win
  task automatic close_pair(input int lane, input bit first_set);
    @(posedge clk);
    #1;
    if (first_set) set_edge[lane] = 1'b1; else clr_edge[lane] = 1'b1;
    #1 set_edge[lane] = 1'b0; clr_edge[lane] = 1'b0;
    #2;
    if (first_set) clr_edge[lane] = 1'b1; else set_edge[lane] = 1'b1;
    #1 set_edge[lane] = 1'b0; clr_edge[lane] = 1'b0;
    model = apply_edge(model, lane, !first_set);
    #2 check("R10", level_o, model);
  endtask

  // Equal-frequency trains on lane 0, clear lagging set by dly cycles
  task automatic duty_run(input int period, input int dly, input int reps);
    int high = 0;
    for (int r = 0; r < reps; r++) begin
      for (int c = 0; c < period; c++) begin
        @(posedge clk);
        #1;
        if (c == 0)   set_edge[0] = 1'b1;
        if (c == dly) clr_edge[0] = 1'b1;
        #2 set_edge[0] = 1'b0; clr_edge[0] = 1'b0;
        @(negedge clk);
        if (level_o[0]) high++;
      end
    end
    model[0] = 1'b0;
    check("R9", LANES'(high), LANES'(dly * reps));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd1931);
    #1 check("R6", level_o, '0);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #3 check("R6", level_o, '0);

    // Directed corners
    do_edge(0, 1'b1, "R1");
    do_edge(0, 1'b1, "R3");
    do_edge(0, 1'b1, "R3");
    do_edge(0, 1'b0, "R2");
    do_edge(0, 1'b0, "R4");
    do_edge(1, 1'b1, "R8");
    check("R8", level_o, 2'b10);
    do_edge(0, 1'b1, "R1");
    do_edge(1, 1'b0, "R8");
    check("R8", level_o, 2'b01);
    close_pair(0, 1'b1);
    close_pair(0, 1'b0);
    close_pair(1, 1'b0);

    // Reset while high, with a set edge during reset
    do_edge(1, 1'b1, "R1");
    @(posedge clk);
    #1 rst = 1'b1;
    model = '0;
    #1 check("R6", level_o, '0);
    #1 set_edge[0] = 1'b1;
    #1 set_edge[0] = 1'b0;
    #1 check("R6", level_o, '0);
    @(posedge clk);
    #6 rst = 1'b0;
    #1 check("R6", level_o, '0);
    do_edge(0, 1'b0, "R4");

    // Constrained random edges
    for (int i = 0; i < 400; i++) begin
      int lane = int'($urandom % LANES);
      bit is_set = bit'($urandom % 2);
      do_edge(lane, is_set, is_set ? "R1" : "R2");
    end

    // Duty-cycle measurement
    do_edge(0, 1'b0, "R2");
    duty_run(20, 7, 5);
    duty_run(16, 12, 4);
    duty_run(10, 1, 6);

    finish_run();
  end
endmodule